// File: doc/BRIEF.md
# Camera Serial Packet Header Parser

This block sits behind the lane aligner of a camera serial receiver. Each clock it may take one aligned word that carries one byte per active lane, with lane 0 holding the earliest byte. It collects the four header bytes of a packet, takes the ECC verdict from an external checker, and decides whether the packet is short or long.

A short packet carries no payload. It can open or close the frame. A long packet is followed by exactly as many payload bytes as its 16-bit word count says. The block forwards those bytes with a per-lane byte mask, raises a line indication while a pixel-line packet is streaming, and then ignores the bus until the input valid drops. The next packet starts after valid rises again, which marks the next sync.

The design is fully registered. Every result appears on the outputs one clock after the input word that caused it is sampled.

Top module: `csi_hdr_parser`

## Requirements
- R1: The header bytes are taken in time order: data identifier, word-count low byte, word-count high byte, then the ECC byte. Within a word, lane 0 comes first. The bytes are gathered across as many words as the lane count needs, so a word count field of 0x0032 yields 50 payload bytes.
- R2: A long packet whose ECC is accepted yields exactly word-count payload bytes, in arrival order. `pay_keep` bit i marks byte lane i (bits 8i+7:8i of `pay_data`) as valid. A final partial word has only its low lanes set, and the unset lanes of `pay_data` read as zero.
- R3: After the last payload byte, `pay_valid` and `in_line` fall. Further words are ignored until `in_valid` has been low for at least one cycle, even when those words look like a header.
- R4: The data type is bits 5:0 of the data identifier; bits 7:6 are ignored. Type 0x00 sets `in_frame`, type 0x01 clears it, and the other short types 0x02 to 0x0F leave it unchanged.
- R5: For an accepted header of type 0x10 or above, `long_packet` is high from the cycle after the header word through the cycle after the final payload word. A zero word count gives exactly one cycle. A short type never raises it.
- R6: `in_line` accompanies every payload word of types 0x18 to 0x3F. It stays low for long types 0x10 to 0x17, which include embedded data 0x12.
- R7: When `ecc_ok` is low on the word that completes a header, `hdr_err` pulses for one cycle. `in_frame` keeps its value, and no payload or long indication follows.
- R8: If `in_valid` drops in the middle of a header or a payload, that packet is abandoned. The next valid word is taken as the first byte of a new header.
- R9: During and right after reset, every output is low.
- R10: `lane_cfg` selects the bytes per word: 2'b00 selects 1 lane, 2'b01 selects 2 lanes, and 2'b10 or 2'b11 select 4 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_cfg | input | 2 | Active lane count selector |
| in_word | input | MAX_LANES*8 | Aligned word, lane 0 in the low byte |
| in_valid | input | 1 | Word valid; a rising edge marks a fresh sync |
| ecc_ok | input | 1 | Header ECC verdict, sampled with the word that completes the header |
| pay_data | output | MAX_LANES*8 | Payload bytes, with unset lanes forced to zero |
| pay_keep | output | MAX_LANES | Per-lane payload byte mask |
| pay_valid | output | 1 | Payload word present |
| in_frame | output | 1 | Between frame start and frame end |
| in_line | output | 1 | Payload word belongs to a pixel line |
| long_packet | output | 1 | A long packet is in progress |
| hdr_err | output | 1 | One-cycle pulse for a rejected header |

## Verification
Each output is one register away from the sampled input word. A payload word driven at one falling edge is therefore on `pay_data` at the next falling edge. The header verdict (`in_frame`, `hdr_err`, `long_packet`) likewise appears one cycle after the word that completes the header. The bench drives and samples on falling edges only, and the monitor compares each payload word in the cycle it shows. After each packet the bench lets three idle cycles pass before it checks the levels and the counted cycles of `long_packet` and `hdr_err`. By then every registered effect of the packet, including the one-cycle tail of `long_packet`, has settled.

// File: rtl/chp_pkg.sv
package chp_pkg;

  typedef logic [2:0] lanes_t;

  typedef enum logic [1:0] {
    ST_HDR   = 2'd0,
    ST_PAY   = 2'd1,
    ST_DRAIN = 2'd2
  } state_e;

  localparam logic [5:0] DT_FRAME_OPEN  = 6'h00;
  localparam logic [5:0] DT_FRAME_CLOSE = 6'h01;
  localparam logic [5:0] DT_LONG_FIRST  = 6'h10;
  localparam logic [5:0] DT_LINE_FIRST  = 6'h18;

  // Bytes carried per word for a lane selector, clamped to the bus width.
  function automatic lanes_t decode_lanes(input logic [1:0] cfg, input int unsigned max_lanes);
    lanes_t n;
    unique case (cfg)
      2'b00:   n = 3'd1;
      2'b01:   n = 3'd2;
      default: n = 3'd4;
    endcase
    if (32'(n) > max_lanes) n = lanes_t'(max_lanes);
    return n;
  endfunction

  function automatic logic is_long_dt(input logic [5:0] dt);
    return dt >= DT_LONG_FIRST;
  endfunction

  function automatic logic is_line_dt(input logic [5:0] dt);
    return dt >= DT_LINE_FIRST;
  endfunction

  // Payload bytes consumed from the current word.
  function automatic lanes_t bytes_this_word(input logic [15:0] rem, input lanes_t n);
    if (rem < {13'd0, n}) return rem[2:0];
    return n;
  endfunction

  function automatic logic [15:0] hdr_word_count(input logic [31:0] hdr);
    return {hdr[23:16], hdr[15:8]};
  endfunction

  function automatic logic [5:0] hdr_data_type(input logic [31:0] hdr);
    return hdr[5:0];
  endfunction

endpackage

// File: rtl/chp_gather.sv
module chp_gather
  import chp_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic [MAX_LANES*8-1:0] word,
  input  lanes_t                 lanes,
  output logic                   done,
  output logic [31:0]            hdr_now
);

  localparam int HDR_BYTES = 4;

  logic [31:0] acc_q;
  logic [2:0]  cnt_q;
  logic [3:0]  cnt_sum;

  always_comb begin
    int idx;
    hdr_now = acc_q;
    for (int b = 0; b < HDR_BYTES; b++) begin
      idx = b - int'(cnt_q);
      if (idx >= 0 && idx < int'(lanes) && idx < MAX_LANES)
        hdr_now[b*8 +: 8] = word[idx*8 +: 8];
    end
  end

  assign cnt_sum = {1'b0, cnt_q} + {1'b0, lanes};
  assign done    = take && (cnt_sum >= 4'(HDR_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (!take || done) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= hdr_now;
      cnt_q <= cnt_sum[2:0];
    end
  end

endmodule

// File: rtl/chp_count.sv
module chp_count
  import chp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] wc,
  input  logic        step,
  input  lanes_t      lanes,
  output logic [15:0] rem,
  output lanes_t      take,
  output logic        last
);

  logic [15:0] rem_q;

  assign rem  = rem_q;
  assign take = bytes_this_word(rem_q, lanes);
  assign last = rem_q <= {13'd0, lanes};

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= wc;
    else if (step) rem_q <= rem_q - {13'd0, take};
  end

endmodule

// File: rtl/chp_status.sv
module chp_status
  import chp_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_evt,
  input  logic                   ecc_ok,
  input  logic [5:0]             dt,
  input  logic                   pay_evt,
  input  logic                   line_pkt,
  input  logic [MAX_LANES*8-1:0] word,
  input  lanes_t                 take,
  output logic [MAX_LANES*8-1:0] pay_data,
  output logic [MAX_LANES-1:0]   pay_keep,
  output logic                   pay_valid,
  output logic                   in_frame,
  output logic                   in_line,
  output logic                   long_packet,
  output logic                   hdr_err
);

  localparam int W = MAX_LANES * 8;

  logic [MAX_LANES-1:0] keep_now;
  logic [W-1:0]         data_now;
  logic                 hdr_good;

  assign hdr_good = hdr_evt && ecc_ok;

  always_comb begin
    for (int i = 0; i < MAX_LANES; i++) begin
      keep_now[i]        = i < int'(take);
      data_now[i*8 +: 8] = word[i*8 +: 8] & {8{keep_now[i]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_data    <= '0;
      pay_keep    <= '0;
      pay_valid   <= 1'b0;
      in_frame    <= 1'b0;
      in_line     <= 1'b0;
      long_packet <= 1'b0;
      hdr_err     <= 1'b0;
    end else begin
      if (hdr_good && dt == DT_FRAME_OPEN)       in_frame <= 1'b1;
      else if (hdr_good && dt == DT_FRAME_CLOSE) in_frame <= 1'b0;
      long_packet <= (hdr_good && is_long_dt(dt)) || pay_evt;
      hdr_err     <= hdr_evt && !ecc_ok;
      pay_valid   <= pay_evt;
      in_line     <= pay_evt && line_pkt;
      pay_data    <= pay_evt ? data_now : '0;
      pay_keep    <= pay_evt ? keep_now : '0;
    end
  end

  // Mask is non-empty and filled from lane 0 upward.
  p_keep_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> (pay_keep != '0) && ((pay_keep & (pay_keep + MAX_LANES'(1))) == '0));

  p_err_keeps_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> in_frame == $past(in_frame));

endmodule

// File: rtl/csi_hdr_parser.sv
module csi_hdr_parser
  import chp_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             lane_cfg,
  input  logic [MAX_LANES*8-1:0] in_word,
  input  logic                   in_valid,
  input  logic                   ecc_ok,
  output logic [MAX_LANES*8-1:0] pay_data,
  output logic [MAX_LANES-1:0]   pay_keep,
  output logic                   pay_valid,
  output logic                   in_frame,
  output logic                   in_line,
  output logic                   long_packet,
  output logic                   hdr_err
);

  state_e      st_q, st_d;
  lanes_t      lanes;
  logic        hdr_take, hdr_done, hdr_evt, pay_evt;
  logic [31:0] hdr_now;
  logic [5:0]  dt;
  logic [15:0] wc, cnt_rem;
  lanes_t      cnt_take;
  logic        cnt_last;
  logic        line_pkt_q;

  assign lanes    = decode_lanes(lane_cfg, MAX_LANES);
  assign hdr_take = (st_q == ST_HDR) && in_valid;
  assign hdr_evt  = hdr_take && hdr_done;
  assign pay_evt  = (st_q == ST_PAY) && in_valid;
  assign dt       = hdr_data_type(hdr_now);
  assign wc       = hdr_word_count(hdr_now);

  chp_gather #(.MAX_LANES(MAX_LANES)) u_gather (
    .clk(clk), .rst_n(rst_n), .take(hdr_take), .word(in_word),
    .lanes(lanes), .done(hdr_done), .hdr_now(hdr_now)
  );

  chp_count u_count (
    .clk(clk), .rst_n(rst_n), .load(hdr_evt), .wc(wc), .step(pay_evt),
    .lanes(lanes), .rem(cnt_rem), .take(cnt_take), .last(cnt_last)
  );

  chp_status #(.MAX_LANES(MAX_LANES)) u_status (
    .clk(clk), .rst_n(rst_n), .hdr_evt(hdr_evt), .ecc_ok(ecc_ok), .dt(dt),
    .pay_evt(pay_evt), .line_pkt(line_pkt_q), .word(in_word), .take(cnt_take),
    .pay_data(pay_data), .pay_keep(pay_keep), .pay_valid(pay_valid),
    .in_frame(in_frame), .in_line(in_line), .long_packet(long_packet),
    .hdr_err(hdr_err)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HDR: if (hdr_evt) begin
        if (!ecc_ok)                          st_d = ST_DRAIN;
        else if (is_long_dt(dt) && wc != '0)  st_d = ST_PAY;
        else                                  st_d = ST_DRAIN;
      end
      ST_PAY: begin
        if (!in_valid)     st_d = ST_HDR;
        else if (cnt_last) st_d = ST_DRAIN;
      end
      ST_DRAIN: if (!in_valid) st_d = ST_HDR;
      default:  st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_HDR;
      line_pkt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (hdr_evt) line_pkt_q <= is_line_dt(dt);
    end
  end

  p_pay_rem_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |-> cnt_rem != '0);

  p_payload_has_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> long_packet);

  p_short_no_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_evt && !is_long_dt(dt)) |=> !long_packet);

  p_line_needs_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_line |-> pay_valid);

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> !hdr_err);

  p_err_no_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> !long_packet && !pay_valid);

endmodule

// File: tb/csi_hdr_parser_test.sv
`timescale 1ns/1ps
module csi_hdr_parser_test;

  localparam int LN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    lane_cfg = 2'b01;
  logic [LN*8-1:0] in_word = '0;
  logic          in_valid = 1'b0;
  logic          ecc_ok = 1'b1;
  logic [LN*8-1:0] pay_data;
  logic [LN-1:0] pay_keep;
  logic          pay_valid, in_frame, in_line, long_packet, hdr_err;

  csi_hdr_parser #(.MAX_LANES(LN)) uut (
    .clk(clk), .rst_n(rst_n), .lane_cfg(lane_cfg), .in_word(in_word),
    .in_valid(in_valid), .ecc_ok(ecc_ok), .pay_data(pay_data),
    .pay_keep(pay_keep), .pay_valid(pay_valid), .in_frame(in_frame),
    .in_line(in_line), .long_packet(long_packet), .hdr_err(hdr_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [LN*8-1:0] data;
    logic [LN-1:0]   keep;
    logic            line;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0, n_bad = 0;
  int   long_cyc = 0, err_cyc = 0;
  bit   done_flag = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expected payload words as the design emits them
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (long_packet) long_cyc++;
      if (hdr_err) err_cyc++;
      if (pay_valid) begin
        if (exp_q.size() == 0) chk("R2 unexpected payload word", 32'd1, 32'd0);
        else begin
          e = exp_q.pop_front();
          chk("R2 payload data", 32'(pay_data), 32'(e.data));
          chk("R2 payload keep", 32'(pay_keep), 32'(e.keep));
          chk("R6 in_line with payload", 32'(in_line), 32'(e.line));
        end
      end
    end
  end

  // Driver: builds the byte stream, pushes expected words, drives it
  task automatic send(input logic [7:0] di, input logic [15:0] wc, input bit ok,
                      input logic [1:0] cfg, input int npay, input int trail,
                      input logic [7:0] trail_di);
    int n;
    int nexp;
    int sent;
    logic [7:0] b[$];
    bit lng, line;
    exp_t e;
    n    = (cfg == 2'b00) ? 1 : (cfg == 2'b01) ? 2 : 4;
    lng  = di[5:0] >= 6'h10;
    line = di[5:0] >= 6'h18;
    nexp = 0;
    b = {};
    b.push_back(di); b.push_back(wc[7:0]); b.push_back(wc[15:8]); b.push_back(8'h3C);
    for (int i = 0; i < npay; i++) b.push_back(8'(i * 3 + 17));
    while ((b.size() % n) != 0) b.push_back(8'hEE);
    for (int k = 0; k < trail * n; k++) b.push_back((k % 4 == 0) ? trail_di : 8'h00);
    if (ok && lng) begin
      sent = (npay < int'(wc)) ? npay : int'(wc);
      for (int p = 0; p < sent; p += n) begin
        int nb;
        nb = (int'(wc) - p < n) ? int'(wc) - p : n;
        e.data = '0;
        for (int l = 0; l < nb; l++) e.data[l*8 +: 8] = b[4 + p + l];
        e.keep = LN'((1 << nb) - 1);
        e.line = line;
        exp_q.push_back(e);
        nexp++;
      end
    end
    long_cyc = 0;
    err_cyc  = 0;
    for (int w = 0; w < b.size() / n; w++) begin
      @(negedge clk);
      lane_cfg = cfg;
      in_valid = 1'b1;
      ecc_ok   = ok;
      in_word  = 32'hA5A5_A5A5;
      for (int l = 0; l < n; l++) in_word[l*8 +: 8] = b[w*n + l];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = '0;
    ecc_ok   = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 all payload words seen", exp_q.size(), 32'd0);
    chk("R5 long_packet cycle count", long_cyc, (ok && lng) ? nexp + 1 : 0);
    chk("R7 hdr_err cycle count", err_cyc, ok ? 32'd0 : 32'd1);
    chk("R3 pay_valid low after packet", 32'(pay_valid), 32'd0);
    chk("R3 in_line low after packet", 32'(in_line), 32'd0);
    chk("R5 long_packet low after packet", 32'(long_packet), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", {25'd0, pay_valid, in_frame, in_line, long_packet, hdr_err, |pay_keep, |pay_data}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 outputs after reset", {25'd0, pay_valid, in_frame, in_line, long_packet, hdr_err, |pay_keep, |pay_data}, 32'd0);

    // R4 R1: frame start on two lanes
    send(8'h00, 16'h0001, 1, 2'b01, 0, 0, 8'h00);
    chk("R4 frame start sets in_frame", 32'(in_frame), 32'd1);

    // R1 R6: embedded data, count 0x0032 = 50 bytes, two lanes, no in_line
    send(8'h12, 16'h0032, 1, 2'b01, 50, 0, 8'h00);
    // R10 R1: one lane, pixel line of 50 bytes
    send(8'h2A, 16'd50, 1, 2'b00, 50, 0, 8'h00);
    // R2 R10: four lanes, partial last word
    send(8'h2B, 16'd5, 1, 2'b10, 5, 0, 8'h00);
    // R3: trailing words shaped like frame end are ignored
    send(8'h24, 16'd7, 1, 2'b01, 7, 3, 8'h01);
    chk("R3 trailing header ignored", 32'(in_frame), 32'd1);
    // R7: bad ECC frame end
    send(8'h01, 16'h0000, 0, 2'b01, 0, 0, 8'h00);
    chk("R7 in_frame kept on bad ECC", 32'(in_frame), 32'd1);
    // R7: bad ECC long header with payload behind it
    send(8'h2A, 16'd6, 0, 2'b01, 6, 0, 8'h00);
    // R4: other short type leaves frame alone
    send(8'h05, 16'h0000, 1, 2'b01, 0, 0, 8'h00);
    chk("R4 short type 0x05 no frame change", 32'(in_frame), 32'd1);
    // R8 R10: abort mid payload, selector 2'b11 = four lanes
    send(8'h2A, 16'd40, 1, 2'b11, 8, 0, 8'h00);

    // R8: partial header on one lane then valid drops
    @(negedge clk);
    lane_cfg = 2'b00; in_valid = 1'b1; in_word = 32'h0000_003F;
    @(negedge clk);
    in_word = 32'h0000_0005;
    @(negedge clk);
    in_valid = 1'b0; in_word = '0;
    repeat (2) @(negedge clk);
    send(8'h01, 16'h0000, 1, 2'b00, 0, 0, 8'h00);
    chk("R8 R4 frame end after partial header", 32'(in_frame), 32'd0);

    // R5: zero-length long packet, trailing frame-start shapes drained
    send(8'h2C, 16'd0, 1, 2'b10, 0, 2, 8'h00);
    chk("R3 drained frame start ignored", 32'(in_frame), 32'd0);
    // R4: virtual-channel bits ignored
    send(8'h40, 16'h0002, 1, 2'b10, 0, 0, 8'h00);
    chk("R4 frame start with upper bits set", 32'(in_frame), 32'd1);
    // R2 R6: exact single four-byte word, highest line type
    send(8'h3F, 16'd4, 1, 2'b10, 4, 0, 8'h00);
    // R6: embedded type with upper bits set, one lane
    send(8'h92, 16'd3, 1, 2'b00, 3, 0, 8'h00);
    send(8'hC1, 16'h0000, 1, 2'b01, 0, 0, 8'h00);
    chk("R4 frame end with upper bits set", 32'(in_frame), 32'd0);

    finish_run();
  end

endmodule